// File: doc/BRIEF.md
# Doorbell and Message Interrupt Unit

This block passes short messages and doorbell signals between a host-side bus master and a local processor. Each direction has two 32-bit message registers, a doorbell register, an interrupt status register and an interrupt mask register. The inbound direction carries traffic from the host to the local processor. The outbound direction carries traffic from the local processor to the host. Each direction drives one interrupt line toward its receiving side.

Both sides share one 32-bit register port. A side-select input says which side makes the access. Offsets 0 to 2 are the sending view of a side: its two message registers and its doorbell in the direction it feeds. Offsets 3 to 7 are the receiving view of that side: the two messages, the doorbell, status and mask of the direction it is fed by. Reads are combinational. Writes take effect at the next clock edge.

Circular queues are handled outside this block. They report here through post-queue not-empty levels and overflow pulses. A machine-check request pulse is also an input.

Top module: `mbx_unit`

## Requirements
- R1: After a synchronous reset, the message and doorbell registers are 0, the status registers read 0, both 9-bit masks read 0x1FF and both interrupt lines are low.
- R2: A write from the sending side to offset 0 or 1 stores message 0 or 1 of its direction. The receiving side reads that message at offset 3 or 4. The write sets status bit 0 (message 0) or bit 1 (message 1) of that direction.
- R3: Writing the status register (offset 6) clears each clearable bit that is written as 1. The clearable bits are 0, 1, 4, 7 and 8. Bit 3 (doorbell) and bit 5 (post-queue not empty) are not changed by this write.
- R4: A mask bit set to 1 disables its source, and a 0 enables it. The mask is written at offset 7, bits 8:0. Each interrupt line equals the OR over bits 8:0 of status AND NOT mask.
- R5: A sender write to its doorbell (offset 2) ORs the written value into the register. Written 0 bits leave the register unchanged.
- R6: The receiver clears doorbell bits by writing 1s to offset 5. Status bit 3 is 1 exactly while any doorbell bit is 1.
- R7: Local-side writes to the outbound doorbell can set only bits 28:0. Bits 31:29 stay 0.
- R8: Status bit 5 of each direction follows that direction's post-queue not-empty input level.
- R9: In the inbound status, a machine-check pulse sets bit 4, a post-queue overflow pulse sets bit 7 and a free-queue overflow pulse sets bit 8. These bits stay set until cleared. Outbound status bits 2, 4, 6, 7 and 8 always read 0.
- R10: Status and mask bits 31:9 read 0. Offsets 0 to 2 read 0. Writes to offsets 3 and 4 change nothing.
- R11: When a status-setting event and a clearing write to the same bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_side | input | 1 | Accessing side: 0 host, 1 local |
| acc_we | input | 1 | Write strobe for this cycle |
| acc_addr | input | 3 | Word offset in the side's view |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data |
| in_pq_nonempty | input | 1 | Inbound post queue holds entries |
| out_pq_nonempty | input | 1 | Outbound post queue holds entries |
| mchk_evt | input | 1 | Machine-check request pulse (inbound) |
| in_post_ovf_evt | input | 1 | Inbound post-queue overflow pulse |
| in_free_ovf_evt | input | 1 | Free-queue overflow pulse (inbound) |
| irq_local | output | 1 | Interrupt toward the local processor |
| irq_host | output | 1 | Interrupt toward the host |

## Verification
Any internal state error shows up on the next read from the receiving side. That includes a lost sticky bit, a doorbell bit cleared by its sender, or a mask bit left wrong after reset. It also shows on an interrupt line in the same cycle as the register edge that caused it, because each line is combinational from the registered status and mask. So the bench reads every receiving-side register and both interrupt lines after every random operation. A divergence is then caught within one access of its cause, not many operations later.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DW    = 32;
    localparam int SW    = 9;
    localparam int NDIR  = 2;
    localparam int AW    = 3;

    localparam int DIR_IN  = 0;
    localparam int DIR_OUT = 1;

    typedef enum logic {
        SIDE_HOST  = 1'b0,
        SIDE_LOCAL = 1'b1
    } side_e;

    // word offsets within one side's view
    localparam logic [AW-1:0] OFF_TX_M0 = 3'd0;
    localparam logic [AW-1:0] OFF_TX_M1 = 3'd1;
    localparam logic [AW-1:0] OFF_TX_DB = 3'd2;
    localparam logic [AW-1:0] OFF_RX_M0 = 3'd3;
    localparam logic [AW-1:0] OFF_RX_M1 = 3'd4;
    localparam logic [AW-1:0] OFF_RX_DB = 3'd5;
    localparam logic [AW-1:0] OFF_STAT  = 3'd6;
    localparam logic [AW-1:0] OFF_MASK  = 3'd7;

    // receiver-side selects (offset minus OFF_RX_DB)
    localparam logic [1:0] RX_DB   = 2'd0;
    localparam logic [1:0] RX_STAT = 2'd1;
    localparam logic [1:0] RX_MASK = 2'd2;

    // status / mask bit positions
    localparam int BIT_M0   = 0;
    localparam int BIT_M1   = 1;
    localparam int BIT_DB   = 3;
    localparam int BIT_MCHK = 4;
    localparam int BIT_PQ   = 5;
    localparam int BIT_POVF = 7;
    localparam int BIT_FOVF = 8;

    localparam logic [SW-1:0] STICKY_IN  = 9'h193;
    localparam logic [SW-1:0] STICKY_OUT = 9'h003;

    typedef struct packed {
        logic          tx_we;
        logic [1:0]    tx_sel;
        logic          rx_we;
        logic [1:0]    rx_sel;
        logic [DW-1:0] data;
    } dir_wr_t;

    typedef struct packed {
        logic [DW-1:0] msg0;
        logic [DW-1:0] msg1;
        logic [DW-1:0] db;
        logic [SW-1:0] stat;
        logic [SW-1:0] mask;
    } dir_view_t;

    // side that feeds a direction
    function automatic side_e sender_of(input int d);
        return (d == DIR_IN) ? SIDE_HOST : SIDE_LOCAL;
    endfunction

    // direction a side receives from
    function automatic int rx_dir_of(input side_e s);
        return (s == SIDE_HOST) ? DIR_OUT : DIR_IN;
    endfunction

    function automatic logic [DW-1:0] widen(input logic [SW-1:0] v);
        return {{(DW-SW){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic          acc_side,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output dir_wr_t       wr [NDIR]
);

    logic [AW-1:0] rx_off;
    assign rx_off = acc_addr - OFF_RX_DB;

    always_comb begin
        for (int d = 0; d < NDIR; d++) begin
            wr[d]      = '0;
            wr[d].data = acc_wdata;
            if (acc_we) begin
                if (side_e'(acc_side) == sender_of(d)) begin
                    if (acc_addr <= OFF_TX_DB) begin
                        wr[d].tx_we  = 1'b1;
                        wr[d].tx_sel = acc_addr[1:0];
                    end
                end else if (acc_addr >= OFF_RX_DB) begin
                    wr[d].rx_we  = 1'b1;
                    wr[d].rx_sel = rx_off[1:0];
                end
            end
        end
    end

endmodule

// File: rtl/mbx_dir.sv
module mbx_dir
    import mbx_pkg::*;
#(
    parameter logic [DW-1:0] DB_WMASK = '1,
    parameter logic [SW-1:0] STICKY   = STICKY_OUT
) (
    input  logic          clk,
    input  logic          rst,
    input  dir_wr_t       wr,
    input  logic [SW-1:0] ev,
    input  logic          pq_lvl,
    output dir_view_t     view,
    output logic          irq
);

    logic [DW-1:0] msg_q [2];
    logic [DW-1:0] db_q;
    logic [SW-1:0] sticky_q;
    logic [SW-1:0] mask_q;
    logic [SW-1:0] set_v;
    logic [SW-1:0] clr_v;
    logic [SW-1:0] stat_v;

    always_comb begin
        set_v = ev;
        if (wr.tx_we && wr.tx_sel == OFF_TX_M0[1:0]) set_v[BIT_M0] = 1'b1;
        if (wr.tx_we && wr.tx_sel == OFF_TX_M1[1:0]) set_v[BIT_M1] = 1'b1;
        set_v = set_v & STICKY;
        clr_v = (wr.rx_we && wr.rx_sel == RX_STAT) ? (wr.data[SW-1:0] & STICKY) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q[0] <= '0;
            msg_q[1] <= '0;
            db_q     <= '0;
            sticky_q <= '0;
            mask_q   <= '1;
        end else begin
            if (wr.tx_we) begin
                case (wr.tx_sel)
                    OFF_TX_M0[1:0]: msg_q[0] <= wr.data;
                    OFF_TX_M1[1:0]: msg_q[1] <= wr.data;
                    OFF_TX_DB[1:0]: db_q     <= db_q | (wr.data & DB_WMASK);
                    default: ;
                endcase
            end else if (wr.rx_we && wr.rx_sel == RX_DB) begin
                db_q <= db_q & ~wr.data;
            end
            if (wr.rx_we && wr.rx_sel == RX_MASK) mask_q <= wr.data[SW-1:0];
            // a set in the same cycle overrides a clear
            sticky_q <= (sticky_q & ~clr_v) | set_v;
        end
    end

    always_comb begin
        stat_v         = sticky_q;
        stat_v[BIT_DB] = |db_q;
        stat_v[BIT_PQ] = pq_lvl;
    end

    assign view.msg0 = msg_q[0];
    assign view.msg1 = msg_q[1];
    assign view.db   = db_q;
    assign view.stat = stat_v;
    assign view.mask = mask_q;
    assign irq       = |(stat_v & ~mask_q);

endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
    import mbx_pkg::*;
(
    input  logic          acc_side,
    input  logic [AW-1:0] acc_addr,
    input  dir_view_t     view [NDIR],
    output logic [DW-1:0] acc_rdata
);

    dir_view_t sel;

    always_comb begin
        sel = view[rx_dir_of(side_e'(acc_side))];
        case (acc_addr)
            OFF_RX_M0: acc_rdata = sel.msg0;
            OFF_RX_M1: acc_rdata = sel.msg1;
            OFF_RX_DB: acc_rdata = sel.db;
            OFF_STAT:  acc_rdata = widen(sel.stat);
            OFF_MASK:  acc_rdata = widen(sel.mask);
            default:   acc_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
    import mbx_pkg::*;
#(
    parameter int DB_LOCK_BITS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_side,
    input  logic          acc_we,
    input  logic [2:0]    acc_addr,
    input  logic [31:0]   acc_wdata,
    output logic [31:0]   acc_rdata,
    input  logic          in_pq_nonempty,
    input  logic          out_pq_nonempty,
    input  logic          mchk_evt,
    input  logic          in_post_ovf_evt,
    input  logic          in_free_ovf_evt,
    output logic          irq_local,
    output logic          irq_host
);

    localparam logic [DW-1:0] OUT_DB_WMASK = {{DB_LOCK_BITS{1'b0}}, {(DW-DB_LOCK_BITS){1'b1}}};

    dir_wr_t       wr    [NDIR];
    dir_view_t     dview [NDIR];
    logic [SW-1:0] ev    [NDIR];
    logic          pq    [NDIR];
    logic          irq   [NDIR];

    always_comb begin
        ev[DIR_IN]           = '0;
        ev[DIR_IN][BIT_MCHK] = mchk_evt;
        ev[DIR_IN][BIT_POVF] = in_post_ovf_evt;
        ev[DIR_IN][BIT_FOVF] = in_free_ovf_evt;
        ev[DIR_OUT]          = '0;
        pq[DIR_IN]           = in_pq_nonempty;
        pq[DIR_OUT]          = out_pq_nonempty;
    end

    mbx_decode u_dec (
        .acc_side  (acc_side),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .wr        (wr)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        localparam logic [DW-1:0] WM = (d == DIR_OUT) ? OUT_DB_WMASK : '1;
        localparam logic [SW-1:0] SM = (d == DIR_IN) ? STICKY_IN : STICKY_OUT;
        mbx_dir #(
            .DB_WMASK (WM),
            .STICKY   (SM)
        ) u_dir (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr[d]),
            .ev     (ev[d]),
            .pq_lvl (pq[d]),
            .view   (dview[d]),
            .irq    (irq[d])
        );
    end

    mbx_rdmux u_rd (
        .acc_side  (acc_side),
        .acc_addr  (acc_addr),
        .view      (dview),
        .acc_rdata (acc_rdata)
    );

    assign irq_local = irq[DIR_IN];
    assign irq_host  = irq[DIR_OUT];

endmodule

// File: rtl/mbx_unit_chk.sv
module mbx_unit_chk
    import mbx_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          acc_side,
    input logic          acc_we,
    input logic [2:0]    acc_addr,
    input logic          mchk_evt,
    input logic          irq_local,
    input logic [31:0]   in_db,
    input logic [31:0]   out_db,
    input logic [8:0]    in_stat,
    input logic [8:0]    out_stat,
    input logic [8:0]    in_mask,
    input logic [8:0]    out_mask
);

    AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_mask == 9'h1FF && out_mask == 9'h1FF)); // R1

    AST_MSG_SETS_STAT: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_side == SIDE_HOST && acc_addr == OFF_TX_M0) |=> in_stat[0]); // R2

    AST_LOCAL_MSG1_STAT: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_side == SIDE_LOCAL && acc_addr == OFF_TX_M1) |=> out_stat[1]); // R2

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((in_stat & ~in_mask) == 9'h0) |-> !irq_local); // R4

    AST_SENDER_KEEPS_DB: assert property (@(posedge clk) disable iff (rst)
        (acc_we && acc_side == SIDE_HOST && acc_addr == OFF_TX_DB)
        |=> ((in_db & $past(in_db)) == $past(in_db))); // R5

    AST_OUT_DB_LOCKED: assert property (@(posedge clk) disable iff (rst)
        out_db[31:29] == 3'b000); // R7

    AST_OUT_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_stat[8:6] == 3'b000 && out_stat[4] == 1'b0 && out_stat[2] == 1'b0)); // R9

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        mchk_evt |=> in_stat[4]); // R11

endmodule

bind mbx_unit mbx_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_side  (acc_side),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .mchk_evt  (mchk_evt),
    .irq_local (irq_local),
    .in_db     (dview[0].db),
    .out_db    (dview[1].db),
    .in_stat   (dview[0].stat),
    .out_stat  (dview[1].stat),
    .in_mask   (dview[0].mask),
    .out_mask  (dview[1].mask)
);

// File: tb/mbx_unit_bench.sv
`timescale 1ns/100ps
module mbx_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_side;
    logic        acc_we;
    logic [2:0]  acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic        in_pq_nonempty;
    logic        out_pq_nonempty;
    logic        mchk_evt;
    logic        in_post_ovf_evt;
    logic        in_free_ovf_evt;
    logic        irq_local;
    logic        irq_host;

    int checks = 0;
    int errors = 0;

    // bench model, index 0 inbound, 1 outbound
    logic [31:0] m_msg  [2][2];
    logic [31:0] m_db   [2];
    logic [8:0]  m_st   [2];
    logic [8:0]  m_mask [2];

    always #2.5 clk = ~clk;

    mbx_unit u_mbx_unit (
        .clk             (clk),
        .rst             (rst),
        .acc_side        (acc_side),
        .acc_we          (acc_we),
        .acc_addr        (acc_addr),
        .acc_wdata       (acc_wdata),
        .acc_rdata       (acc_rdata),
        .in_pq_nonempty  (in_pq_nonempty),
        .out_pq_nonempty (out_pq_nonempty),
        .mchk_evt        (mchk_evt),
        .in_post_ovf_evt (in_post_ovf_evt),
        .in_free_ovf_evt (in_free_ovf_evt),
        .irq_local       (irq_local),
        .irq_host        (irq_host)
    );

    function automatic logic [8:0] sticky_of(input int d);
        return (d == 0) ? 9'h193 : 9'h003;
    endfunction

    function automatic logic [8:0] exp_stat(input int d);
        logic [8:0] s;
        s    = m_st[d];
        s[3] = (m_db[d] != 0);
        s[5] = (d == 0) ? in_pq_nonempty : out_pq_nonempty;
        return s;
    endfunction

    function automatic logic exp_irq(input int d);
        return |(exp_stat(d) & ~m_mask[d]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic side, input logic [2:0] a);
        int d;
        d = side ? 0 : 1;
        case (a)
            3'd3: return m_msg[d][0];
            3'd4: return m_msg[d][1];
            3'd5: return m_db[d];
            3'd6: return {23'd0, exp_stat(d)};
            3'd7: return {23'd0, m_mask[d]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_msg[d][0] = '0; m_msg[d][1] = '0;
            m_db[d] = '0; m_st[d] = '0; m_mask[d] = 9'h1FF;
        end
    endtask

    task automatic model_write(input logic side, input logic [2:0] a, input logic [31:0] v);
        int tx, rx;
        tx = side ? 1 : 0;
        rx = side ? 0 : 1;
        case (a)
            3'd0, 3'd1: begin
                m_msg[tx][a[0]] = v;
                m_st[tx][a[0]]  = 1'b1;
            end
            3'd2: m_db[tx] = m_db[tx] | (tx == 1 ? (v & 32'h1FFF_FFFF) : v);
            3'd5: m_db[rx] = m_db[rx] & ~v;
            3'd6: m_st[rx] = m_st[rx] & ~(v[8:0] & sticky_of(rx));
            3'd7: m_mask[rx] = v[8:0];
            default: ;
        endcase
    endtask

    // one clock: optional write and inbound event pulses {free, post, mchk}
    task automatic step(input logic we, input logic side, input logic [2:0] a,
                        input logic [31:0] v, input logic [2:0] evs);
        @(negedge clk);
        acc_we = we; acc_side = side; acc_addr = a; acc_wdata = v;
        mchk_evt = evs[0]; in_post_ovf_evt = evs[1]; in_free_ovf_evt = evs[2];
        @(negedge clk);
        acc_we = 1'b0; mchk_evt = 1'b0; in_post_ovf_evt = 1'b0; in_free_ovf_evt = 1'b0;
        if (we) model_write(side, a, v);
        if (evs[0]) m_st[0][4] = 1'b1;
        if (evs[1]) m_st[0][7] = 1'b1;
        if (evs[2]) m_st[0][8] = 1'b1;
    endtask

    task automatic rd(input logic side, input logic [2:0] a, output logic [31:0] v);
        acc_side = side; acc_addr = a; acc_we = 1'b0;
        #1;
        v = acc_rdata;
    endtask

    task automatic rd_chk(input string req, input logic side, input logic [2:0] a,
                          input logic [31:0] exp);
        logic [31:0] v;
        rd(side, a, v);
        chk(req, v, exp);
    endtask

    task automatic check_all();
        logic [31:0] v;
        for (int s = 0; s < 2; s++) begin
            for (int a = 3; a < 8; a++) begin
                rd(s[0], a[2:0], v);
                case (a)
                    3, 4: chk("R2", v, exp_rd(s[0], a[2:0]));
                    5:    chk("R6", v, exp_rd(s[0], a[2:0]));
                    6:    chk("R3", v, exp_rd(s[0], a[2:0]));
                    default: chk("R4", v, exp_rd(s[0], a[2:0]));
                endcase
            end
        end
        chk("R4 irq_local", {31'd0, irq_local}, {31'd0, exp_irq(0)});
        chk("R4 irq_host",  {31'd0, irq_host},  {31'd0, exp_irq(1)});
    endtask

    initial begin : watchdog
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; acc_we = 1'b0; acc_side = 1'b0; acc_addr = '0; acc_wdata = '0;
        in_pq_nonempty = 1'b0; out_pq_nonempty = 1'b0;
        mchk_evt = 1'b0; in_post_ovf_evt = 1'b0; in_free_ovf_evt = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 in mask", 1'b1, 3'd7, 32'h1FF);
        rd_chk("R1 out mask", 1'b0, 3'd7, 32'h1FF);
        rd_chk("R1 in stat", 1'b1, 3'd6, 32'h0);
        chk("R1 irq_local", {31'd0, irq_local}, 32'd0);
        chk("R1 irq_host", {31'd0, irq_host}, 32'd0);
        check_all();

        // R2 message from host to local
        step(1'b1, 1'b0, 3'd0, 32'hA5A5_0F0F, 3'b000);
        rd_chk("R2 in msg0", 1'b1, 3'd3, 32'hA5A5_0F0F);
        rd_chk("R2 in stat bit0", 1'b1, 3'd6, 32'h001);
        step(1'b1, 1'b1, 3'd1, 32'h1234_5678, 3'b000);
        rd_chk("R2 out msg1", 1'b0, 3'd4, 32'h1234_5678);
        rd_chk("R2 out stat bit1", 1'b0, 3'd6, 32'h002);

        // R4 enable message 0 interrupt on the local side
        chk("R4 masked", {31'd0, irq_local}, 32'd0);
        step(1'b1, 1'b1, 3'd7, 32'h1FE, 3'b000);
        chk("R4 enabled", {31'd0, irq_local}, 32'd1);

        // R5 doorbell OR-set, zero write no effect
        step(1'b1, 1'b0, 3'd2, 32'h0000_0005, 3'b000);
        step(1'b1, 1'b0, 3'd2, 32'h0000_0000, 3'b000);
        rd_chk("R5 db or", 1'b1, 3'd5, 32'h0000_0005);

        // R3 status clear keeps doorbell bit 3
        step(1'b1, 1'b1, 3'd6, 32'hFFFF_FFFF, 3'b000);
        rd_chk("R3 clear", 1'b1, 3'd6, 32'h008);
        chk("R4 irq after clear", {31'd0, irq_local}, 32'd0);

        // R6 write back clears
        step(1'b1, 1'b1, 3'd5, 32'h0000_0004, 3'b000);
        rd_chk("R6 partial", 1'b1, 3'd5, 32'h0000_0001);
        rd_chk("R6 bit3 held", 1'b1, 3'd6, 32'h008);
        step(1'b1, 1'b1, 3'd5, 32'h0000_0001, 3'b000);
        rd_chk("R6 bit3 gone", 1'b1, 3'd6, 32'h000);

        // R7 locked top bits
        step(1'b1, 1'b1, 3'd2, 32'hFFFF_FFFF, 3'b000);
        rd_chk("R7 out db", 1'b0, 3'd5, 32'h1FFF_FFFF);

        // R8 post-queue level
        @(negedge clk); in_pq_nonempty = 1'b1;
        rd_chk("R8 pq set", 1'b1, 3'd6, 32'h020);
        step(1'b1, 1'b1, 3'd6, 32'h020, 3'b000);
        rd_chk("R8 pq not cleared", 1'b1, 3'd6, 32'h020);
        in_pq_nonempty = 1'b0;
        rd_chk("R8 pq clear", 1'b1, 3'd6, 32'h000);

        // R9 inbound events, outbound reserved zero
        step(1'b0, 1'b0, 3'd0, 32'h0, 3'b111);
        rd_chk("R9 in events", 1'b1, 3'd6, 32'h190);
        rd_chk("R9 out rsvd", 1'b0, 3'd6, {23'd0, exp_stat(1)});

        // R11 set beats clear
        step(1'b1, 1'b1, 3'd6, 32'h010, 3'b001);
        rd_chk("R11 set wins", 1'b1, 3'd6, 32'h190);

        // R10 read of send offsets and ignored writes
        rd_chk("R10 off0", 1'b0, 3'd0, 32'h0);
        rd_chk("R10 off2", 1'b1, 3'd2, 32'h0);
        step(1'b1, 1'b1, 3'd3, 32'hDEAD_BEEF, 3'b000);
        rd_chk("R10 ro write", 1'b1, 3'd3, 32'hA5A5_0F0F);
        step(1'b1, 1'b0, 3'd7, 32'hFFFF_FE00, 3'b000);
        rd_chk("R10 mask hi", 1'b0, 3'd7, 32'h0);
        check_all();

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  a;
            logic [31:0] v2;
            logic        s;
            s  = $urandom_range(0, 1);
            a  = $urandom_range(0, 7);
            v2 = $urandom;
            if ($urandom_range(0, 3) == 0) v2 = v2 & 32'h0000_01FF;
            if ($urandom_range(0, 7) == 0) in_pq_nonempty = ~in_pq_nonempty;
            if ($urandom_range(0, 7) == 0) out_pq_nonempty = ~out_pq_nonempty;
            step(1'b1, s, a, v2, ($urandom_range(0, 5) == 0) ? 3'($urandom_range(0, 7)) : 3'b000);
            check_all();
        end

        rd(1'b0, 3'd0, v);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule